// File: doc/BRIEF.md
# System Clock Source Switch

This block chooses which of four candidate oscillators drives the system clock inside a clock controller. The four are a fast internal oscillator, a slow low-power internal oscillator, an external crystal oscillator and a PLL output. Software turns each oscillator on through a control register and watches its ready flag. It then requests a new system source through a 2-bit select field. The oscillators and the PLL are not built here. Each one is a ready-delay counter driven by its enable bit. The PLL counter also needs its own chosen input to be running. The actual clocks are shown as one clock-enable per source.

A switch is glitch-free. The select readback keeps the source actually in use until the requested source is ready. After that, all enables go low for one reference cycle, and then only the new source is enabled. Software confirms a switch by polling the readback until it equals the code it wrote.

Interlocks protect running hardware. The enable of the running source cannot be cleared. The enable of the PLL's input cannot be cleared while the PLL is in use. The external oscillator's bypass bit is locked while that oscillator is on or still ready. The PLL configuration is locked while the PLL is on or still ready. A write to a locked field is dropped silently and the old value is kept.

The fast internal oscillator also has a power-of-two divider. Its effect appears as a divided tick.

Top module: `sysclk_switch`

## Requirements
- R1: After reset, the select readback is 0 and `src_gate` is 4'b0001. The control register reads 0x101: the fast oscillator is on (bit 0) and ready (bit 8), and every other bit is 0. The PLL configuration register reads 0.
- R2: Control register, address 0. The enable bits are: fast oscillator bit 0, low-power bit 1, external bit 2, PLL bit 5. The ready flags for sources 0..3 are bits 8..11. A ready flag changes to match its enable once the enable has differed from it for the configured delay, counted in reference cycles.
- R3: The select readback (address 1, bits 1:0) keeps the old code while the requested source is not ready. It changes to the requested code two clock edges after the edge at which that source's ready flag is first seen high.
- R4: At most one bit of `src_gate` is set. Between two sources, all bits are low for exactly one cycle. Otherwise the set bit is bit `sys_src`.
- R5: A write that clears the enable of the source in use is ignored, and so is one that clears the enable of the source being switched to. The enable stays 1.
- R6: While the PLL is in use, a write that clears the enable of the PLL's selected input source is ignored.
- R7: The external bypass bit (control bit 6) is updated by a write only while the external oscillator's enable and ready flag are both 0. Otherwise it keeps its value.
- R8: The PLL configuration register (address 2) has three fields: input source in bits 1:0 (3 = no input), pre-divider in bits 7:2, multiplier in bits 16:8. A write to it is dropped while the PLL enable or the PLL ready flag is 1.
- R9: The PLL ready flag can rise only while its input field is not 3 and the selected input's ready flag is 1.
- R10: The fast oscillator's divider is control bits 4:3 and is always writable. `hs_tick` is high only while the fast oscillator is ready, and then once every 2^divider cycles. The phase follows a free-running count of cycles since reset.
- R11: Select codes are 0 = fast internal, 1 = low-power internal, 2 = external, 3 = PLL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Register address: 0 control, 1 select, 2 PLL configuration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_src | output | 2 | Source code currently driving the system clock |
| src_gate | output | 4 | Per-source clock enables, at most one high |
| hs_tick | output | 1 | Divided tick of the fast internal oscillator |

## Verification
The hardest states to reach are the interlocked ones. Examples are clearing the external oscillator's enable while it feeds a PLL that is itself the system source, and bringing up the PLL with no valid input. The stimulus gets there step by step. It enables the external oscillator, configures the PLL onto it while the PLL is off, and waits for both ready flags. It switches to the PLL and then issues clearing writes. Later it parks the system on the low-power oscillator. That frees both the bypass bit and the PLL configuration, so a PLL start with input code 3 can be tried, and then a valid start on the low-power input.

// File: rtl/sysclk_pkg.sv
// Package: shared encodings and register field positions for the system
// clock source switch. Assumes a 32-bit register bus and four sources.
package sysclk_pkg;
    localparam int NSRC  = 4;
    localparam int SELW  = 2;
    localparam int DATAW = 32;
    localparam int DIVW  = 2;

    typedef enum logic [SELW-1:0] {
        SRC_HS  = 2'd0,
        SRC_LP  = 2'd1,
        SRC_XO  = 2'd2,
        SRC_PLL = 2'd3
    } src_e;

    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_SEL = 2'd1;
    localparam logic [1:0] ADDR_PLL = 2'd2;

    localparam int CTL_ON_HS  = 0;
    localparam int CTL_ON_LP  = 1;
    localparam int CTL_ON_XO  = 2;
    localparam int CTL_DIV_LO = 3;
    localparam int CTL_ON_PLL = 5;
    localparam int CTL_BYP    = 6;
    localparam int CTL_RDY_LO = 8;

    typedef struct packed {
        logic [8:0] mul;
        logic [5:0] pre;
        logic [1:0] src;
    } pll_cfg_t;
    localparam int PLLW = $bits(pll_cfg_t);
endpackage

// File: rtl/sysclk_rdy_model.sv
// Module: ready-flag model of one oscillator. The flag follows 'run'
// after 'run' has differed from it for DLY consecutive cycles.
// Assumes DLY >= 1. RST_RDY is the flag value after reset.
module sysclk_rdy_model #(
    parameter int DLY     = 4,
    parameter bit RST_RDY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic rdy
);
    localparam int CW = (DLY < 2) ? 1 : $clog2(DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt;

    // Count cycles of mismatch between run and rdy; flip rdy at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            rdy <= RST_RDY;
        end else if (run != rdy) begin
            if (cnt == LAST) begin
                rdy <= run;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/sysclk_switch_ctl.sv
// Module: break-before-make switch sequencer. When the requested source
// differs from the active one and is ready, it spends one cycle with all
// enables low, then makes the target active. Assumes req is registered.
module sysclk_switch_ctl
    import sysclk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  src_e            req,
    input  logic [NSRC-1:0] rdy,
    output src_e            active,
    output logic            gap,
    output src_e            tgt,
    output logic [NSRC-1:0] gate
);
    // Sequence the switch: idle -> gap (target latched) -> active updated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= SRC_HS;
            gap    <= 1'b0;
            tgt    <= SRC_HS;
        end else if (gap) begin
            active <= tgt;
            gap    <= 1'b0;
        end else if ((req != active) && rdy[req]) begin
            gap <= 1'b1;
            tgt <= req;
        end
    end

    // Drive the one-hot enable of the active source, none during the gap.
    always_comb begin
        gate = '0;
        if (!gap) gate[active] = 1'b1;
    end
endmodule

// File: rtl/sysclk_regs.sv
// Module: register file with interlocks. It holds the enables, the fast
// divider, the bypass bit, the PLL configuration and the requested source.
// Clears of in-use enables and writes to locked fields are dropped.
// Assumes rdy, active, gap and tgt come from registers.
module sysclk_regs
    import sysclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [DATAW-1:0] bus_wdata,
    input  logic [NSRC-1:0]  rdy,
    input  src_e             active,
    input  logic             gap,
    input  src_e             tgt,
    output logic [NSRC-1:0]  on,
    output logic [DIVW-1:0]  div,
    output logic             byp,
    output pll_cfg_t         pll_cfg,
    output src_e             req,
    output logic [DATAW-1:0] bus_rdata
);
    logic [NSRC-1:0] in_use;
    logic [NSRC-1:0] keep_on;
    logic [NSRC-1:0] wr_on;
    logic            wr_ctl;
    logic            wr_sel;
    logic            wr_pll;
    logic            unused_bits;

    assign wr_ctl = bus_wr && (bus_addr == ADDR_CTL);
    assign wr_sel = bus_wr && (bus_addr == ADDR_SEL);
    assign wr_pll = bus_wr && (bus_addr == ADDR_PLL);
    assign wr_on  = {bus_wdata[CTL_ON_PLL], bus_wdata[CTL_ON_XO],
                     bus_wdata[CTL_ON_LP], bus_wdata[CTL_ON_HS]};
    assign unused_bits = ^{bus_wdata[DATAW-1:PLLW], bus_wdata[7]};

    // Mark sources whose enable must not be cleared: the active source, the
    // pending target, and the PLL's input while the PLL is in use.
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            in_use[i] = (active == src_e'(i)) || (gap && (tgt == src_e'(i)));
        end
        for (int i = 0; i < NSRC; i++) begin
            keep_on[i] = in_use[i] ||
                         ((i != NSRC - 1) && in_use[NSRC-1] &&
                          (pll_cfg.src == SELW'(i)));
        end
    end

    // Update the control fields; the bypass bit is locked while the
    // external oscillator is on or ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on  <= NSRC'(1);
            div <= '0;
            byp <= 1'b0;
        end else if (wr_ctl) begin
            on  <= wr_on | keep_on;
            div <= bus_wdata[CTL_DIV_LO +: DIVW];
            if (!on[SRC_XO] && !rdy[SRC_XO]) byp <= bus_wdata[CTL_BYP];
        end
    end

    // Update the PLL configuration only while the PLL is fully stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_cfg <= '0;
        end else if (wr_pll && !on[SRC_PLL] && !rdy[SRC_PLL]) begin
            pll_cfg <= pll_cfg_t'(bus_wdata[PLLW-1:0]);
        end
    end

    // Capture the requested system source.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= SRC_HS;
        else if (wr_sel) req <= src_e'(bus_wdata[SELW-1:0]);
    end

    // Read mux; the select readback returns the source actually in use.
    always_comb begin
        case (bus_addr)
            ADDR_CTL: bus_rdata = {20'b0, rdy, 1'b0, byp, on[SRC_PLL], div,
                                   on[SRC_XO], on[SRC_LP], on[SRC_HS]};
            ADDR_SEL: bus_rdata = {{(DATAW-SELW){1'b0}}, active};
            ADDR_PLL: bus_rdata = {{(DATAW-PLLW){1'b0}}, pll_cfg};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sysclk_switch.sv
// Module: top of the system clock source switch. Instantiates one ready
// model per source, the register file and the switch sequencer, and
// produces the divided fast-oscillator tick. Delays are reference cycles.
module sysclk_switch
    import sysclk_pkg::*;
#(
    parameter int HS_DLY  = 4,
    parameter int LP_DLY  = 3,
    parameter int XO_DLY  = 10,
    parameter int PLL_DLY = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [DATAW-1:0] bus_wdata,
    output logic [DATAW-1:0] bus_rdata,
    output logic [SELW-1:0]  sys_src,
    output logic [NSRC-1:0]  src_gate,
    output logic             hs_tick
);
    localparam int TCW = (1 << DIVW) - 1;

    logic [NSRC-1:0] on_vec;
    logic [NSRC-1:0] rdy_vec;
    logic [NSRC-1:0] run_vec;
    logic [DIVW-1:0] div;
    logic            byp;
    pll_cfg_t        pll_cfg;
    src_e            req;
    src_e            active;
    src_e            tgt;
    logic            gap;
    logic            pll_in_ok;
    logic [TCW-1:0]  tcnt;
    logic [TCW-1:0]  tmask;
    logic            unused_cfg;

    assign unused_cfg = ^{byp, pll_cfg.mul, pll_cfg.pre};
    assign pll_in_ok  = (pll_cfg.src != SRC_PLL) && rdy_vec[pll_cfg.src];

    // One ready model per source; the PLL also needs its input running.
    for (genvar g = 0; g < NSRC; g++) begin : g_osc
        localparam int D = (g == 0) ? HS_DLY : (g == 1) ? LP_DLY :
                           (g == 2) ? XO_DLY : PLL_DLY;
        if (g == NSRC - 1) begin : g_pll
            assign run_vec[g] = on_vec[g] && pll_in_ok;
        end else begin : g_plain
            assign run_vec[g] = on_vec[g];
        end
        sysclk_rdy_model #(.DLY(D), .RST_RDY(g == 0)) u_rdy (
            .clk(clk), .rst_n(rst_n), .run(run_vec[g]), .rdy(rdy_vec[g])
        );
    end

    sysclk_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rdy(rdy_vec), .active(active), .gap(gap),
        .tgt(tgt), .on(on_vec), .div(div), .byp(byp), .pll_cfg(pll_cfg),
        .req(req), .bus_rdata(bus_rdata)
    );

    sysclk_switch_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .req(req), .rdy(rdy_vec),
        .active(active), .gap(gap), .tgt(tgt), .gate(src_gate)
    );

    assign sys_src = active;

    // Free-running phase counter for the divided tick.
    always_ff @(posedge clk) begin
        if (!rst_n) tcnt <= '0;
        else tcnt <= tcnt + 1'b1;
    end

    assign tmask   = TCW'((1 << div) - 1);
    assign hs_tick = rdy_vec[SRC_HS] && ((tcnt & tmask) == '0);
endmodule

// File: rtl/sysclk_switch_chk.sv
// Module: property checker for the system clock source switch, bound to
// the top. It watches the outputs and the per-source enable and ready flags.
module sysclk_switch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sys_src,
    input logic [3:0] src_gate,
    input logic [3:0] rdy,
    input logic [3:0] on,
    input logic       hs_tick
);
    // R4: never two enables at once
    assert_gate_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_gate));
    // R4: an enable, when present, belongs to the reported source
    assert_gate_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_gate != 4'b0) |-> (src_gate == (4'b0001 << sys_src)));
    // R4: the all-low gap lasts one cycle
    assert_gap_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_gate == 4'b0) |=> (src_gate != 4'b0));
    // R3: the reported source only changes right after a gap
    assert_change_after_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sys_src) |-> ($past(src_gate) == 4'b0));
    // R5: an enabled clock is from a source that is on and ready
    assert_gated_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_gate & ~on) == 4'b0) && ((src_gate & ~rdy) == 4'b0));
    // R10: no tick while the fast oscillator is not ready
    assert_tick_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hs_tick |-> rdy[0]);
endmodule

bind sysclk_switch sysclk_switch_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sys_src(sys_src), .src_gate(src_gate),
    .rdy(rdy_vec), .on(on_vec), .hs_tick(hs_tick)
);

// File: tb/sim_sysclk_switch.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with the outputs on each falling edge, plus directed register
// readback checks with literal expectations.
module sim_sysclk_switch;
    localparam int DHS = 4, DLP = 3, DXO = 10, DPLL = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [1:0]  sys_src;
    logic [3:0]  src_gate;
    logic        hs_tick;

    int tests = 0, fails = 0;
    bit armed = 1'b0;
    bit done = 1'b0;

    // reference model state
    bit m_on[4], m_rdy[4];
    int m_cnt[4];
    int m_div, m_psrc, m_pre, m_mul, m_req, m_act, m_tgt, m_n;
    bit m_byp, m_gap;

    always #4 clk = ~clk;

    sysclk_switch #(.HS_DLY(DHS), .LP_DLY(DLP), .XO_DLY(DXO), .PLL_DLY(DPLL)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_src(sys_src),
        .src_gate(src_gate), .hs_tick(hs_tick)
    );

    function automatic int dly(int i);
        return (i == 0) ? DHS : (i == 1) ? DLP : (i == 2) ? DXO : DPLL;
    endfunction

    function automatic logic [31:0] ctl(bit hs, bit lp, bit xo, bit pll, int dv, bit bp);
        return {25'd0, bp, pll, 2'(dv), xo, lp, hs};
    endfunction

    function automatic logic [31:0] pllw(int s, int p, int m);
        return {15'd0, 9'(m), 6'(p), 2'(s)};
    endfunction

    function automatic logic [31:0] exp_ctl();
        return {20'd0, m_rdy[3], m_rdy[2], m_rdy[1], m_rdy[0], 1'b0, m_byp,
                m_on[3], 2'(m_div), m_on[2], m_on[1], m_on[0]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_on[i] = (i == 0); m_rdy[i] = (i == 0); m_cnt[i] = 0;
        end
        m_div = 0; m_psrc = 0; m_pre = 0; m_mul = 0; m_req = 0; m_act = 0;
        m_tgt = 0; m_n = 0; m_byp = 0; m_gap = 0;
    endtask

    task automatic model_step();
        bit o_on[4], o_rdy[4], inuse[4], prot[4], run;
        int o_psrc, o_req;
        o_on = m_on; o_rdy = m_rdy; o_psrc = m_psrc; o_req = m_req;
        for (int i = 0; i < 4; i++) inuse[i] = (m_act == i) || (m_gap && m_tgt == i);
        for (int i = 0; i < 3; i++) prot[i] = inuse[i] || (inuse[3] && o_psrc == i);
        prot[3] = inuse[3];
        if (bus_wr) begin
            case (bus_addr)
                2'd0: begin
                    m_on[0] = bus_wdata[0] | prot[0];
                    m_on[1] = bus_wdata[1] | prot[1];
                    m_on[2] = bus_wdata[2] | prot[2];
                    m_on[3] = bus_wdata[5] | prot[3];
                    m_div = int'(bus_wdata[4:3]);
                    if (!o_on[2] && !o_rdy[2]) m_byp = bus_wdata[6];
                end
                2'd1: m_req = int'(bus_wdata[1:0]);
                2'd2: if (!o_on[3] && !o_rdy[3]) begin
                    m_psrc = int'(bus_wdata[1:0]);
                    m_pre = int'(bus_wdata[7:2]);
                    m_mul = int'(bus_wdata[16:8]);
                end
                default: ;
            endcase
        end
        for (int i = 0; i < 4; i++) begin
            run = o_on[i];
            if (i == 3) run = o_on[3] && (o_psrc != 3) && o_rdy[o_psrc];
            if (run != o_rdy[i]) begin
                if (m_cnt[i] == dly(i) - 1) begin
                    m_rdy[i] = run; m_cnt[i] = 0;
                end else m_cnt[i]++;
            end else m_cnt[i] = 0;
        end
        if (m_gap) begin
            m_act = m_tgt; m_gap = 0;
        end else if (o_req != m_act && o_rdy[o_req]) begin
            m_gap = 1; m_tgt = o_req;
        end
        m_n = (m_n + 1) % 8;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (armed && rst_n) begin
            check("R3 sys_src", 32'(sys_src), 32'(m_act));
            check("R4 src_gate", 32'(src_gate), m_gap ? 32'd0 : (32'd1 << m_act));
            check("R10 hs_tick", 32'(hs_tick),
                  32'(m_rdy[0] && ((m_n % (1 << m_div)) == 0)));
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        @(negedge clk); #1;
        bus_addr = a; #1;
        v = bus_rdata;
    endtask

    task automatic rd_model(string tag);
        logic [31:0] v;
        rd(2'd0, v); check({tag, " ctl vs model"}, v, exp_ctl());
        rd(2'd1, v); check({tag, " sel vs model"}, v, 32'(m_act));
        rd(2'd2, v); check({tag, " pll vs model"}, v, pllw(m_psrc, m_pre, m_mul));
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        wait_n(3);
        @(negedge clk); #1; rst_n = 1'b1;
        armed = 1'b1;
        // R1 reset state
        rd(2'd0, v); check("R1 ctl after reset", v, 32'h101);
        rd(2'd1, v); check("R1 sel after reset", v, 32'd0);
        rd(2'd2, v); check("R1 pll cfg after reset", v, 32'd0);
        check("R1 gate after reset", 32'(src_gate), 32'b0001);

        // R10 divider field and tick rate
        wr(2'd0, ctl(1, 0, 0, 0, 2, 0));
        rd(2'd0, v); check("R10 divider readback", v, 32'h111);
        wait_n(20);

        // R3 external oscillator start and switch
        wr(2'd0, ctl(1, 0, 1, 0, 2, 0));
        wr(2'd1, 32'd2);
        wait_n(2);
        rd(2'd1, v); check("R3 sel holds before ready", v, 32'd0);
        wait_n(12);
        rd(2'd1, v); check("R3 R11 sel external", v, 32'd2);
        rd(2'd0, v); check("R2 external ready bit10", 32'(v[10]), 32'd1);
        check("R4 gate external", 32'(src_gate), 32'b0100);

        // R5 clear of active source ignored, R7 bypass locked
        wr(2'd0, ctl(1, 0, 0, 0, 2, 0));
        rd(2'd0, v); check("R5 active enable kept", 32'(v[2]), 32'd1);
        wr(2'd0, ctl(1, 0, 1, 0, 2, 1));
        rd(2'd0, v); check("R7 bypass locked", 32'(v[6]), 32'd0);

        // R8 PLL configuration accepted while off, dropped while on
        wr(2'd2, pllw(2, 5, 79));
        rd(2'd2, v); check("R8 pll cfg accepted", v, pllw(2, 5, 79));
        wr(2'd0, ctl(1, 0, 1, 1, 2, 0));
        wait_n(16);
        rd(2'd0, v); check("R2 R9 pll ready bit11", 32'(v[11]), 32'd1);
        wr(2'd2, pllw(1, 3, 40));
        rd(2'd2, v); check("R8 pll cfg locked", v, pllw(2, 5, 79));

        // R11 switch to PLL, R6 input protected, R5 PLL enable protected
        wr(2'd1, 32'd3);
        wait_n(4);
        rd(2'd1, v); check("R11 sel pll", v, 32'd3);
        wr(2'd0, ctl(1, 0, 0, 1, 2, 0));
        rd(2'd0, v); check("R6 pll input enable kept", 32'(v[2]), 32'd1);
        wr(2'd0, ctl(1, 0, 1, 0, 2, 0));
        rd(2'd0, v); check("R5 pll enable kept", 32'(v[5]), 32'd1);
        rd_model("R5");

        // park on low-power, then release external and PLL
        wr(2'd0, ctl(1, 1, 1, 1, 2, 0));
        wr(2'd1, 32'd1);
        wait_n(8);
        rd(2'd1, v); check("R11 sel low-power", v, 32'd1);
        wr(2'd0, ctl(1, 1, 0, 0, 2, 0));
        wait_n(16);
        rd(2'd0, v); check("R2 ready flags fall", 32'(v[11:8]), 32'b0011);
        wr(2'd0, ctl(1, 1, 0, 0, 2, 1));
        rd(2'd0, v); check("R7 bypass written when off", 32'(v[6]), 32'd1);
        wr(2'd2, pllw(3, 1, 10));
        rd(2'd2, v); check("R8 pll cfg written when off", v, pllw(3, 1, 10));

        // R9 PLL with no input never becomes ready
        wr(2'd0, ctl(1, 1, 0, 1, 2, 1));
        wait_n(20);
        rd(2'd0, v); check("R9 pll no input not ready", 32'(v[11]), 32'd0);
        wr(2'd0, ctl(1, 1, 0, 0, 2, 1));
        wait_n(2);
        wr(2'd2, pllw(1, 1, 10));
        wr(2'd0, ctl(1, 1, 0, 1, 2, 1));
        wait_n(15);
        rd(2'd0, v); check("R9 pll on low-power ready", 32'(v[11]), 32'd1);

        // back to fast oscillator; its clear is ignored; divider 0
        wr(2'd1, 32'd0);
        wait_n(4);
        rd(2'd1, v); check("R3 sel back to fast", v, 32'd0);
        wr(2'd0, ctl(0, 1, 0, 1, 0, 1));
        rd(2'd0, v); check("R5 fast enable kept", 32'(v[0]), 32'd1);
        wait_n(10);
        rd_model("R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule